// File: doc/BRIEF.md
# Eight-bit Arithmetic and Logic Unit with Selective Status Update

This block is the arithmetic and logic unit of a small RISC core. Each issued operation takes two register operands, an immediate byte, a select that swaps the second register operand for the immediate, and the current six-bit status vector. One clock later it returns a result, 8 bits wide for byte operations and 16 bits for multiplies and register-pair operations, together with the new status vector.

Every operation rewrites only the status bits it is defined to affect. All other bits are copied from the incoming status vector. The carry-in for the with-carry adds, subtracts and rotates is the carry bit of that incoming vector. The multiplier can be built either as a single product operator or as a generated shift-and-add array; both variants give the same results. Instruction decode, the register file and the program counter sit outside the block.

Top module: `alu8_core`

## Requirements
- R1: While `rst_n` is low, `res_q`, `flags_q` and `out_valid` are all zero.
- R2: An operation presented with `op_valid` high appears on `res_q`/`flags_q` with `out_valid` high after one rising edge. While `op_valid` is low, `out_valid` is low and `res_q`/`flags_q` hold their values. Status bit positions: C=0, Z=1, N=2, V=3, S=4, H=5.
- R3: Codes 0 (add), 1 (add with carry), 2 (subtract) and 3 (subtract with borrow) combine `opa` with `opb`, or with `imm` when `use_imm` is 1. They write H (carry or borrow out of bit 3), V (signed overflow), C (carry or borrow out of bit 7), N (bit 7), Z (result zero) and S.
- R4: Codes 4 (AND), 5 (OR) and 6 (XOR) use the same operand select. They write Z, N, S, and V=0, and keep C and H.
- R5: Code 7 returns 0xFF minus `opa` and writes C=1, V=0, N, Z and S, keeping H. Code 8 returns 0x00 minus `opa` and writes all six bits: C=1 unless `opa` is 0, V=1 only for 0x80, and H is the borrow out of bit 3.
- R6: Code 9 (increment) and code 10 (decrement) of `opa` write Z, N and S. V is set only for input 0x7F (increment) or 0x80 (decrement). C and H are kept.
- R7: The shifts act on `opa`. Code 11 shifts right with 0 into bit 7. Code 12 rotates right with the old C into bit 7. Code 13 shifts right keeping bit 7. For these three, C takes the old bit 0. Code 14 rotates left with the old C into bit 0, and C takes the old bit 7. All four write Z, N, V=N xor C and S, and keep H.
- R8: Code 15 exchanges the two nibbles of `opa` and leaves all six status bits unchanged. Unused codes 24 to 31 return zero and also leave the status bits unchanged.
- R9: Codes 16 (unsigned × unsigned), 17 (signed × signed) and 18 (signed `opa` × unsigned `opb`) return the 16-bit product of `opa` and `opb`, with C = product bit 15 and Z = product zero. All other bits are kept.
- R10: Codes 19, 20 and 21 take the same three signedness forms and return the product shifted left by one. C is bit 15 of the unshifted product and Z tests the shifted value. All other bits are kept.
- R11: Code 22 adds and code 23 subtracts the zero-extended low six bits of `imm` to or from the pair {`opb`,`opa`}. They write C (carry or borrow out of bit 15), V (signed overflow), N (bit 15), Z and S, and keep H.
- R12: Whenever an operation writes N or V, it also writes S equal to N xor V.
- R13: Every byte operation (codes 0 to 15) returns zero in `res_q[15:8]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Issue strobe for the operation on the inputs |
| op_code | input | 5 | Operation code |
| opa | input | 8 | First register operand, low byte of a pair |
| opb | input | 8 | Second register operand, high byte of a pair |
| imm | input | 8 | Immediate byte |
| use_imm | input | 1 | Selects `imm` in place of `opb` for codes 0 to 6 |
| status_in | input | 6 | Current status vector, carry-in in bit 0 |
| res_q | output | 16 | Registered result |
| flags_q | output | 6 | Registered updated status vector |
| out_valid | output | 1 | Result registers were loaded at the last edge |

## Verification
The assertions assume that `status_in` and `op_code` are valid at the edge where `op_valid` is sampled high, because every preserved-bit property compares against that sampled value. They also assume that an unused code is never issued where a write is expected. The stimulus drives all inputs only on falling edges and holds them across the next rising edge. It walks `status_in` through patterns in which the preserved bits differ from the bits being written, so that a wrongly written bit is visible. It issues only defined codes, except where the bench checks R8 on purpose.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

   localparam int FLAG_W = 6;
   localparam int FL_C   = 0;
   localparam int FL_Z   = 1;
   localparam int FL_N   = 2;
   localparam int FL_V   = 3;
   localparam int FL_S   = 4;
   localparam int FL_H   = 5;

   typedef enum logic [4:0] {
      OP_ADD     = 5'd0,
      OP_ADDC    = 5'd1,
      OP_SUB     = 5'd2,
      OP_SUBC    = 5'd3,
      OP_AND     = 5'd4,
      OP_OR      = 5'd5,
      OP_XOR     = 5'd6,
      OP_NOT     = 5'd7,
      OP_NEG     = 5'd8,
      OP_INC     = 5'd9,
      OP_DEC     = 5'd10,
      OP_SHR     = 5'd11,
      OP_RORC    = 5'd12,
      OP_SAR     = 5'd13,
      OP_ROLC    = 5'd14,
      OP_SWAPN   = 5'd15,
      OP_MUL_UU  = 5'd16,
      OP_MUL_SS  = 5'd17,
      OP_MUL_SU  = 5'd18,
      OP_FMUL_UU = 5'd19,
      OP_FMUL_SS = 5'd20,
      OP_FMUL_SU = 5'd21,
      OP_ADDW    = 5'd22,
      OP_SUBW    = 5'd23
   } alu_op_e;

   function automatic logic op_is_narrow(logic [4:0] c);
      return c <= 5'd15;
   endfunction

   function automatic logic op_is_mul(logic [4:0] c);
      return (c >= 5'd16) && (c <= 5'd21);
   endfunction

   function automatic logic op_is_logic(logic [4:0] c);
      return (c >= 5'd4) && (c <= 5'd6);
   endfunction

   function automatic logic op_is_incdec(logic [4:0] c);
      return (c == 5'd9) || (c == 5'd10);
   endfunction

   function automatic logic op_writes_s(logic [4:0] c);
      return (c <= 5'd14) || (c == 5'd22) || (c == 5'd23);
   endfunction

   function automatic logic op_keeps_h(logic [4:0] c);
      return (c >= 5'd4 && c <= 5'd7) || (c >= 5'd9);
   endfunction

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
   parameter int DATA_W = 8,
   parameter int HALF_W = 4
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic              cin,
   input  logic              sub,
   output logic [DATA_W-1:0] r,
   output logic              c,
   output logic              h,
   output logic              v
);
   localparam int MSB = DATA_W - 1;

   logic [DATA_W:0] full;
   logic [HALF_W:0] low;

   always_comb begin
      if (sub) begin
         full = {1'b0, a} - {1'b0, b} - {{DATA_W{1'b0}}, cin};
         low  = {1'b0, a[HALF_W-1:0]} - {1'b0, b[HALF_W-1:0]} - {{HALF_W{1'b0}}, cin};
      end else begin
         full = {1'b0, a} + {1'b0, b} + {{DATA_W{1'b0}}, cin};
         low  = {1'b0, a[HALF_W-1:0]} + {1'b0, b[HALF_W-1:0]} + {{HALF_W{1'b0}}, cin};
      end
   end

   assign r = full[DATA_W-1:0];
   assign c = full[DATA_W];
   assign h = low[HALF_W];
   assign v = sub ? ((a[MSB] & ~b[MSB] & ~r[MSB]) | (~a[MSB] & b[MSB] & r[MSB]))
                  : ((a[MSB] & b[MSB] & ~r[MSB]) | (~a[MSB] & ~b[MSB] & r[MSB]));

endmodule

// File: rtl/alu8_bitops.sv
module alu8_bitops
   import alu8_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  alu_op_e           op,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic              cin,
   output logic [DATA_W-1:0] r,
   output logic              c
);
   localparam int MSB  = DATA_W - 1;
   localparam int HALF = DATA_W / 2;

   always_comb begin
      r = '0;
      c = 1'b0;
      case (op)
         OP_AND:   r = a & b;
         OP_OR:    r = a | b;
         OP_XOR:   r = a ^ b;
         OP_NOT: begin
            r = ~a;
            c = 1'b1;
         end
         OP_SHR: begin
            r = {1'b0, a[MSB:1]};
            c = a[0];
         end
         OP_RORC: begin
            r = {cin, a[MSB:1]};
            c = a[0];
         end
         OP_SAR: begin
            r = {a[MSB], a[MSB:1]};
            c = a[0];
         end
         OP_ROLC: begin
            r = {a[MSB-1:0], cin};
            c = a[MSB];
         end
         OP_SWAPN: r = {a[HALF-1:0], a[MSB:HALF]};
         default: ;
      endcase
   end

endmodule

// File: rtl/alu8_mul.sv
module alu8_mul #(
   parameter int DATA_W   = 8,
   parameter int MUL_IMPL = 0
) (
   input  logic [DATA_W-1:0]   a,
   input  logic [DATA_W-1:0]   b,
   input  logic                a_signed,
   input  logic                b_signed,
   input  logic                frac,
   output logic [2*DATA_W-1:0] p,
   output logic                c,
   output logic                z
);
   localparam int PW  = 2 * DATA_W;
   localparam int MSB = DATA_W - 1;

   logic [PW-1:0] a_ext;
   logic [PW-1:0] b_ext;
   logic [PW-1:0] prod;

   assign a_ext = {{DATA_W{a_signed & a[MSB]}}, a};
   assign b_ext = {{DATA_W{b_signed & b[MSB]}}, b};

   generate
      if (MUL_IMPL == 0) begin : g_op
         assign prod = a_ext * b_ext;
      end else begin : g_array
         logic [DATA_W:0][PW-1:0] acc;
         assign acc[0] = '0;
         for (genvar i = 0; i < DATA_W; i++) begin : g_row
            logic [PW-1:0] pp;
            assign pp = b[i] ? (a_ext << i) : '0;
            if (i == DATA_W - 1) begin : g_top
               assign acc[i+1] = b_signed ? (acc[i] - pp) : (acc[i] + pp);
            end else begin : g_mid
               assign acc[i+1] = acc[i] + pp;
            end
         end
         assign prod = acc[DATA_W];
      end
   endgenerate

   assign p = frac ? {prod[PW-2:0], 1'b0} : prod;
   assign c = prod[PW-1];
   assign z = (p == '0);

endmodule

// File: rtl/alu8_pairop.sv
module alu8_pairop #(
   parameter int DATA_W = 8,
   parameter int K_W    = 6
) (
   input  logic [DATA_W-1:0]   lo,
   input  logic [DATA_W-1:0]   hi,
   input  logic [K_W-1:0]      k,
   input  logic                sub,
   output logic [2*DATA_W-1:0] r,
   output logic                c,
   output logic                v
);
   localparam int PW = 2 * DATA_W;

   logic [PW-1:0] pair;
   logic [PW-1:0] kx;
   logic [PW:0]   sum;

   assign pair = {hi, lo};
   assign kx   = {{(PW-K_W){1'b0}}, k};
   assign sum  = sub ? ({1'b0, pair} - {1'b0, kx}) : ({1'b0, pair} + {1'b0, kx});
   assign r    = sum[PW-1:0];
   assign c    = sum[PW];
   assign v    = sub ? (pair[PW-1] & ~r[PW-1]) : (~pair[PW-1] & r[PW-1]);

endmodule

// File: rtl/alu8_core.sv
module alu8_core
   import alu8_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int K_W      = 6,
   parameter int MUL_IMPL = 0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                op_valid,
   input  logic [4:0]          op_code,
   input  logic [DATA_W-1:0]   opa,
   input  logic [DATA_W-1:0]   opb,
   input  logic [DATA_W-1:0]   imm,
   input  logic                use_imm,
   input  logic [FLAG_W-1:0]   status_in,
   output logic [2*DATA_W-1:0] res_q,
   output logic [FLAG_W-1:0]   flags_q,
   output logic                out_valid
);
   localparam int PW     = 2 * DATA_W;
   localparam int MSB    = DATA_W - 1;
   localparam int HALF_W = 4;

   generate
      if (DATA_W < 8 || (DATA_W % 2) != 0) begin : g_bad_width
         $error("alu8_core: DATA_W must be even and at least 8");
      end
      if (K_W < 1 || K_W > DATA_W) begin : g_bad_k
         $error("alu8_core: K_W must lie in 1..DATA_W");
      end
      if (MUL_IMPL != 0 && MUL_IMPL != 1) begin : g_bad_mul
         $error("alu8_core: MUL_IMPL must be 0 or 1");
      end
   endgenerate

   alu_op_e           op;
   logic [DATA_W-1:0] b_eff;
   logic              cin;

   assign op    = alu_op_e'(op_code);
   assign b_eff = use_imm ? imm : opb;
   assign cin   = status_in[FL_C];

   // adder operand steering
   logic [DATA_W-1:0] add_a, add_b, add_r;
   logic              add_ci, add_sub, add_c, add_h, add_v;

   always_comb begin
      add_a   = opa;
      add_b   = b_eff;
      add_ci  = 1'b0;
      add_sub = 1'b0;
      case (op)
         OP_ADDC: add_ci = cin;
         OP_SUB:  add_sub = 1'b1;
         OP_SUBC: begin
            add_sub = 1'b1;
            add_ci  = cin;
         end
         OP_NEG: begin
            add_a   = '0;
            add_b   = opa;
            add_sub = 1'b1;
         end
         OP_INC: add_b = {{(DATA_W-1){1'b0}}, 1'b1};
         OP_DEC: begin
            add_b   = {{(DATA_W-1){1'b0}}, 1'b1};
            add_sub = 1'b1;
         end
         default: ;
      endcase
   end

   alu8_addsub #(.DATA_W(DATA_W), .HALF_W(HALF_W)) u_add (
      .a(add_a), .b(add_b), .cin(add_ci), .sub(add_sub),
      .r(add_r), .c(add_c), .h(add_h), .v(add_v)
   );

   logic [DATA_W-1:0] bit_r;
   logic              bit_c;

   alu8_bitops #(.DATA_W(DATA_W)) u_bit (
      .op(op), .a(opa), .b(b_eff), .cin(cin), .r(bit_r), .c(bit_c)
   );

   logic          mul_as, mul_bs, mul_fr, mul_c, mul_z;
   logic [PW-1:0] mul_p;

   assign mul_as = (op == OP_MUL_SS) || (op == OP_MUL_SU) ||
                   (op == OP_FMUL_SS) || (op == OP_FMUL_SU);
   assign mul_bs = (op == OP_MUL_SS) || (op == OP_FMUL_SS);
   assign mul_fr = (op == OP_FMUL_UU) || (op == OP_FMUL_SS) || (op == OP_FMUL_SU);

   alu8_mul #(.DATA_W(DATA_W), .MUL_IMPL(MUL_IMPL)) u_mul (
      .a(opa), .b(opb), .a_signed(mul_as), .b_signed(mul_bs), .frac(mul_fr),
      .p(mul_p), .c(mul_c), .z(mul_z)
   );

   logic [PW-1:0] pr_r;
   logic          pr_c, pr_v;

   alu8_pairop #(.DATA_W(DATA_W), .K_W(K_W)) u_pair (
      .lo(opa), .hi(opb), .k(imm[K_W-1:0]), .sub(op == OP_SUBW),
      .r(pr_r), .c(pr_c), .v(pr_v)
   );

   // result and selective status merge
   logic [PW-1:0]     nres;
   logic [FLAG_W-1:0] nfl;

   always_comb begin
      nres = '0;
      nfl  = status_in;
      case (op)
         OP_ADD, OP_ADDC, OP_SUB, OP_SUBC, OP_NEG: begin
            nres      = {{DATA_W{1'b0}}, add_r};
            nfl[FL_C] = add_c;
            nfl[FL_H] = add_h;
            nfl[FL_V] = add_v;
            nfl[FL_N] = add_r[MSB];
            nfl[FL_Z] = (add_r == '0);
            nfl[FL_S] = add_r[MSB] ^ add_v;
         end
         OP_INC, OP_DEC: begin
            nres      = {{DATA_W{1'b0}}, add_r};
            nfl[FL_V] = add_v;
            nfl[FL_N] = add_r[MSB];
            nfl[FL_Z] = (add_r == '0);
            nfl[FL_S] = add_r[MSB] ^ add_v;
         end
         OP_AND, OP_OR, OP_XOR, OP_NOT: begin
            nres      = {{DATA_W{1'b0}}, bit_r};
            nfl[FL_V] = 1'b0;
            nfl[FL_N] = bit_r[MSB];
            nfl[FL_Z] = (bit_r == '0);
            nfl[FL_S] = bit_r[MSB];
            if (op == OP_NOT) nfl[FL_C] = bit_c;
         end
         OP_SHR, OP_RORC, OP_SAR, OP_ROLC: begin
            nres      = {{DATA_W{1'b0}}, bit_r};
            nfl[FL_C] = bit_c;
            nfl[FL_N] = bit_r[MSB];
            nfl[FL_Z] = (bit_r == '0);
            nfl[FL_V] = bit_r[MSB] ^ bit_c;
            nfl[FL_S] = bit_c;
         end
         OP_SWAPN: nres = {{DATA_W{1'b0}}, bit_r};
         OP_MUL_UU, OP_MUL_SS, OP_MUL_SU, OP_FMUL_UU, OP_FMUL_SS, OP_FMUL_SU: begin
            nres      = mul_p;
            nfl[FL_C] = mul_c;
            nfl[FL_Z] = mul_z;
         end
         OP_ADDW, OP_SUBW: begin
            nres      = pr_r;
            nfl[FL_C] = pr_c;
            nfl[FL_V] = pr_v;
            nfl[FL_N] = pr_r[PW-1];
            nfl[FL_Z] = (pr_r == '0);
            nfl[FL_S] = pr_r[PW-1] ^ pr_v;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_q     <= '0;
         flags_q   <= '0;
         out_valid <= 1'b0;
      end else begin
         out_valid <= op_valid;
         if (op_valid) begin
            res_q   <= nres;
            flags_q <= nfl;
         end
      end
   end

endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk
   import alu8_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input logic                clk,
   input logic                rst_n,
   input logic                op_valid,
   input logic [4:0]          op_code,
   input logic [FLAG_W-1:0]   status_in,
   input logic [2*DATA_W-1:0] res_q,
   input logic [FLAG_W-1:0]   flags_q,
   input logic                out_valid
);

   AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid |=> out_valid); // R2

   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |=> (!out_valid && $stable(res_q) && $stable(flags_q))); // R2

   AST_NIBBLE_SWAP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code == 5'd15) |=> flags_q == $past(status_in)); // R8

   AST_HALF_CARRY_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_keeps_h(op_code)) |=> flags_q[FL_H] == $past(status_in[FL_H])); // R4

   AST_STEP_KEEPS_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_is_incdec(op_code)) |=> flags_q[FL_C] == $past(status_in[FL_C])); // R6

   AST_MUL_ONLY_ZC: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_is_mul(op_code)) |=> flags_q[5:2] == $past(status_in[5:2])); // R9

   AST_SIGN_CONSISTENT: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_writes_s(op_code)) |=> flags_q[FL_S] == (flags_q[FL_N] ^ flags_q[FL_V])); // R12

   AST_LOGIC_V_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_is_logic(op_code)) |=> (!flags_q[FL_V] && flags_q[FL_C] == $past(status_in[FL_C]))); // R4

   AST_NARROW_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_is_narrow(op_code)) |=> res_q[2*DATA_W-1:DATA_W] == '0); // R13

   AST_ZERO_FLAG_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code <= 5'd14) |=> flags_q[FL_Z] == (res_q[DATA_W-1:0] == '0)); // R3

endmodule

bind alu8_core alu8_core_chk #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
   .status_in(status_in), .res_q(res_q), .flags_q(flags_q), .out_valid(out_valid)
);

// File: tb/sim_alu8_core.sv
`timescale 1ns/1ps
module sim_alu8_core;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0;
   logic [4:0]  op_code = '0;
   logic [7:0]  opa = '0, opb = '0, imm = '0;
   logic        use_imm = 1'b0;
   logic [5:0]  status_in = '0;
   logic [15:0] res_q;
   logic [5:0]  flags_q;
   logic        out_valid;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   alu8_core u0 (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
      .opa(opa), .opb(opb), .imm(imm), .use_imm(use_imm), .status_in(status_in),
      .res_q(res_q), .flags_q(flags_q), .out_valid(out_valid)
   );

   function automatic int s8(int x);
      return (x >= 128) ? x - 256 : x;
   endfunction

   function automatic int s16(int x);
      return (x >= 32768) ? x - 65536 : x;
   endfunction

   // expected {result, flags}; flag order C0 Z1 N2 V3 S4 H5
   function automatic logic [21:0] model(int op, int a, int bx, int k, bit sel, logic [5:0] st);
      int b, ci, r, full, hs, sr, p, pu;
      logic [5:0] f;
      bit nb, vb;
      b  = sel ? k : bx;
      ci = st[0];
      f  = st;
      r  = 0;
      case (op)
         0, 1, 2, 3, 8: begin
            int aa, bb, cc;
            aa = (op == 8) ? 0 : a;
            bb = (op == 8) ? a : b;
            cc = (op == 1 || op == 3) ? ci : 0;
            if (op <= 1) begin
               full = aa + bb + cc;
               hs   = (aa % 16) + (bb % 16) + cc;
               sr   = s8(aa) + s8(bb) + cc;
               f[0] = full > 255;
               f[5] = hs > 15;
            end else begin
               full = aa - bb - cc;
               hs   = (aa % 16) - (bb % 16) - cc;
               sr   = s8(aa) - s8(bb) - cc;
               f[0] = full < 0;
               f[5] = hs < 0;
            end
            r  = full & 255;
            vb = (sr > 127) || (sr < -128);
            f[3] = vb;
         end
         4: r = a & b;
         5: r = a | b;
         6: r = a ^ b;
         7: begin r = 255 - a; f[0] = 1; end
         9:  begin r = (a + 1) & 255; f[3] = (a == 127); end
         10: begin r = (a + 255) & 255; f[3] = (a == 128); end
         11: begin r = a / 2; f[0] = a % 2; end
         12: begin r = ci * 128 + a / 2; f[0] = a % 2; end
         13: begin r = (a / 128) * 128 + a / 2; f[0] = a % 2; end
         14: begin r = (a * 2) % 256 + ci; f[0] = a / 128; end
         15: r = (a % 16) * 16 + a / 16;
         16, 17, 18, 19, 20, 21: begin
            int xa, xb, m;
            m  = op % 3 == 1 ? 0 : (op % 3 == 2 ? 1 : 2);
            xa = (m == 0) ? a : s8(a);
            xb = (m == 1) ? s8(bx) : bx;
            pu = (xa * xb) & 65535;
            p  = (op >= 19) ? (pu * 2) & 65535 : pu;
            f[0] = pu >= 32768;
            f[1] = p == 0;
            r = p;
         end
         22, 23: begin
            int pr, kk;
            pr = bx * 256 + a;
            kk = k % 64;
            full = (op == 22) ? pr + kk : pr - kk;
            sr   = (op == 22) ? s16(pr) + kk : s16(pr) - kk;
            f[0] = (full > 65535) || (full < 0);
            r    = full & 65535;
            f[3] = (sr > 32767) || (sr < -32768);
            f[2] = r >= 32768;
            f[1] = r == 0;
            f[4] = f[2] ^ f[3];
         end
         default: r = 0;
      endcase
      if (op <= 14) begin
         nb   = r >= 128;
         f[2] = nb;
         f[1] = (r == 0);
         if (op >= 4 && op <= 7) f[3] = 0;
         if (op >= 11) f[3] = nb ^ f[0];
         f[4] = f[2] ^ f[3];
      end
      return {r[15:0], f};
   endfunction

   task automatic apply(int op, int a, int b, int k, bit sel, logic [5:0] st, string tag);
      logic [21:0] exp_v;
      @(negedge clk);
      op_valid  = 1'b1;
      op_code   = op[4:0];
      opa       = a[7:0];
      opb       = b[7:0];
      imm       = k[7:0];
      use_imm   = sel;
      status_in = st;
      @(posedge clk);
      #1;
      exp_v = model(op, a, b, k, sel, st);
      checks++;
      if ({res_q, flags_q} !== exp_v || out_valid !== 1'b1) begin
         errors++;
         $display("FAIL %s op=%0d a=%02h b=%02h k=%02h sel=%0b st=%02h actual=%04h/%02h/%0b expected=%04h/%02h/1",
                  tag, op, a, b, k, sel, st, res_q, flags_q, out_valid, exp_v[21:6], exp_v[5:0]);
      end
   endtask

   task automatic idle_check();
      logic [15:0] r0;
      logic [5:0]  f0;
      r0 = res_q;
      f0 = flags_q;
      @(negedge clk);
      op_valid  = 1'b0;
      op_code   = 5'd0;
      opa       = 8'h5A;
      opb       = 8'hC3;
      status_in = ~status_in;
      @(posedge clk);
      #1;
      checks++;
      if (res_q !== r0 || flags_q !== f0 || out_valid !== 1'b0) begin
         errors++;
         $display("FAIL R2 idle hold actual=%04h/%02h/%0b expected=%04h/%02h/0",
                  res_q, flags_q, out_valid, r0, f0);
      end
   endtask

   function automatic logic [5:0] stpat(int a, int b, int op);
      return 6'((a * 5 + b * 3 + op * 7) ^ (b >> 2));
   endfunction

   initial begin
      repeat (3) @(posedge clk);
      #1;
      checks++;
      if (res_q !== 16'h0 || flags_q !== 6'h0 || out_valid !== 1'b0) begin
         errors++;
         $display("FAIL R1 reset actual=%04h/%02h/%0b expected=0000/00/0", res_q, flags_q, out_valid);
      end
      @(negedge clk);
      rst_n = 1'b1;

      // R3 and R4: add/sub/logic families, register and immediate forms
      for (int op = 0; op <= 6; op++) begin
         for (int a = 0; a < 256; a++) begin
            for (int bi = 0; bi < 16; bi++) begin
               int b;
               b = (bi * 17 + a) % 256;
               apply(op, a, b, (b * 7 + 3) % 256, bit'(bi % 2), stpat(a, bi, op),
                     op <= 3 ? "R3" : "R4");
            end
         end
         idle_check();
      end

      // R5 R6 R7 R8: unary byte operations, both carry-in values
      for (int op = 7; op <= 15; op++) begin
         for (int a = 0; a < 256; a++) begin
            for (int cv = 0; cv < 2; cv++) begin
               logic [5:0] st;
               st = {stpat(a, cv, op)} & 6'h3E;
               st[0] = cv[0];
               apply(op, a, 255 - a, a, 1'b0, st,
                     op <= 8 ? "R5" : (op <= 10 ? "R6" : (op <= 14 ? "R7" : "R8")));
            end
         end
      end

      // R8: unused code returns zero and keeps status
      apply(27, 8'h81, 8'h42, 8'h11, 1'b0, 6'h2D, "R8");

      // R9 and R10: multiplies in all signedness forms
      for (int op = 16; op <= 21; op++) begin
         for (int a = 0; a < 256; a++) begin
            for (int bi = 0; bi < 16; bi++) begin
               int b;
               b = (bi == 0) ? 0 : (bi == 15 ? 255 : (bi * 37 + a) % 256);
               apply(op, a, b, 0, 1'b0, stpat(a, bi, op), op <= 18 ? "R9" : "R10");
            end
         end
      end

      // R11: pair add/subtract of six-bit immediate, boundaries included
      for (int op = 22; op <= 23; op++) begin
         for (int pi = 0; pi < 256; pi++) begin
            int lo, hi;
            lo = (pi < 4) ? 255 - pi * 85 : (pi * 29) % 256;
            hi = (pi % 4 == 0) ? 8'h7F : ((pi % 4 == 1) ? 8'h80 : ((pi % 4 == 2) ? 8'hFF : (pi * 11) % 256));
            if (pi == 5) begin lo = 0; hi = 0; end
            for (int k = 0; k < 64; k++) begin
               apply(op, lo, hi, k + ((pi % 4) * 64), 1'b0, stpat(lo, k, op), "R11");
            end
         end
         idle_check();
      end

      // R12 R13 spot checks on specific boundary values
      apply(9, 8'h7F, 0, 0, 1'b0, 6'h01, "R12");
      apply(10, 8'h80, 0, 0, 1'b0, 6'h00, "R12");
      apply(0, 8'hFF, 8'h01, 0, 1'b0, 6'h00, "R13");

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #950000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL R2 watchdog actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule